// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block models the read side of a bit-serial configuration store that feeds a programmable logic device while that device loads itself as the clock master. The store holds `2**ADDR_W` one-bit locations; 16, 17 and 18 give the usual 64K, 128K and 256K sizes, and a small default keeps elaboration light. Each rising edge while the block is selected moves an internal location counter forward by one, and the bit at the current location is shown on a serial data output. That output has a separate drive-enable, so the tri-state pin is modelled without a high-impedance value.

One input does two jobs: it enables the output and it clears the counter. Which level of that input clears the counter is chosen by a stored polarity bit, so a board needs no inverter. When the last location has been consumed, the block lets go of the data line and pulls its active-low cascade output low. That output drives the active-low chip select of the next store in a chain, so several stores deliver one unbroken stream. The array and the polarity bit are loaded through a simple preload port, which works only while the serial-enable input is low (programming mode).

Top module: `cfgrom_reader`

## Requirements
- R1: Locations are read in rising address order starting at location 0. The bit at the current location is on `dout_o` as soon as the block is selected, and each enabled rising edge moves to the next location.
- R2: `dout_oe_o` is 1 only when all four of these hold: `ser_en_i` is 1, `ce_n_i` is 0, the reset/enable input is inactive, and the array is not yet exhausted. Whenever `dout_oe_o` is 0, `dout_o` is 0.
- R3: With `ce_n_i` at 1, `dout_oe_o` is 0 whatever the reset/enable level, and the location counter does not advance.
- R4: While `ser_en_i` is 1 and the reset/enable input is active, the counter and the end-of-array flag are cleared at each rising edge, whatever the level of `ce_n_i`. The next read then starts at location 0.
- R5: If the stored polarity bit is 1, `rst_oe_i` = 1 is the active (clearing) level. If it is 0, `rst_oe_i` = 0 is active. After `rst_n` the bit takes the value of parameter `POL_INIT`, which defaults to 1.
- R6: The rising edge that consumes the last location (`2**ADDR_W - 1`) makes `ceo_n_o` go to 0 and `dout_oe_o` go to 0. Later enabled edges do not wrap the counter to location 0.
- R7: Once the array is exhausted, `ceo_n_o` equals `ce_n_i` while the reset/enable input is inactive. It is 1 while that input is active, and after the clear it stays 1 until the whole array has been read again.
- R8: With `ser_en_i` at 0, `dout_oe_o` is 0 and `ceo_n_o` is 1, `ce_n_i` has no effect, and the counter holds its value.
- R9: A rising edge with `ld_we_i` = 1 and `ser_en_i` = 0 writes `ld_bit_i` to location `ld_addr_i`. A rising edge with `pol_we_i` = 1 and `ser_en_i` = 0 writes `pol_bit_i` to the polarity bit. Both writes are ignored while `ser_en_i` is 1.
- R10: When a second instance takes its `ce_n_i` from the first instance's `ceo_n_o`, the two instances deliver all bits of the first array and then all bits of the second. There is no gap cycle, and exactly one instance drives in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; every action happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_en_i | input | 1 | 1 selects read mode, 0 selects programming mode |
| ce_n_i | input | 1 | Active-low chip select |
| rst_oe_i | input | 1 | Combined counter-clear / output-enable; the active level is set by the polarity bit |
| ld_we_i | input | 1 | Preload write strobe for one array bit |
| ld_addr_i | input | ADDR_W | Preload location |
| ld_bit_i | input | 1 | Preload data bit |
| pol_we_i | input | 1 | Write strobe for the polarity bit |
| pol_bit_i | input | 1 | New polarity value |
| dout_o | output | 1 | Serial data value (0 when not driven) |
| dout_oe_o | output | 1 | 1 when the serial data pin is driven |
| ceo_n_o | output | 1 | Active-low cascade output to the next store |

## Verification
The bound checker watches, on every cycle, the behaviour that does not depend on history: no drive in standby, during a clear or in programming mode, and a low cascade output only when the data line is released and chip select is low. It also checks that the counter is frozen in standby, cleared after an active reset/enable level, and held at its last location with no wrap. The bench scenarios are the only place that shows the actual bit order of a full read-out, the effect of both polarity settings, writes that are ignored outside programming mode, and the gapless hand-off between two chained instances.

// File: rtl/cfgrom_pkg.sv
`timescale 1ns/1ps
package cfgrom_pkg;

    // Per-cycle commands from the pin decoder to the location counter
    typedef struct packed {
        logic clear;   // clear counter and end flag
        logic step;    // advance one location
    } seq_ctl_t;

    // True when the reset/enable pin sits at its clearing level
    function automatic logic rst_level_hit(input logic pol, input logic pin);
        return pol ? pin : ~pin;
    endfunction

endpackage

// File: rtl/cfgrom_bitstore.sv
`timescale 1ns/1ps
module cfgrom_bitstore #(
    parameter int ADDR_W   = 10,
    parameter bit POL_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic              ld_we_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              ld_bit_i,
    input  logic              pol_we_i,
    input  logic              pol_bit_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_bit_o,
    output logic              pol_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic             pol;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prog_i && ld_we_i) begin
            st_d.bits[ld_addr_i] = ld_bit_i;
        end
        if (prog_i && pol_we_i) begin
            st_d.pol = pol_bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= '0;
            st_q.pol  <= POL_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_bit_o = st_q.bits[rd_addr_i];
    assign pol_o    = st_q.pol;

endmodule

// File: rtl/cfgrom_addr_seq.sv
`timescale 1ns/1ps
module cfgrom_addr_seq
    import cfgrom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_ctl_t          ctl_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_i.clear) begin
            st_d.addr = '0;
            st_d.done = 1'b0;
        end else if (ctl_i.step && !st_q.done) begin
            if (st_q.addr == LAST_ADDR) begin
                st_d.done = 1'b1;          // hold address, no wrap
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign done_o = st_q.done;

endmodule

// File: rtl/cfgrom_pin_ctrl.sv
`timescale 1ns/1ps
module cfgrom_pin_ctrl
    import cfgrom_pkg::*;
(
    input  logic     ser_en_i,
    input  logic     ce_n_i,
    input  logic     rst_oe_i,
    input  logic     pol_i,
    input  logic     done_i,
    input  logic     rd_bit_i,
    output seq_ctl_t ctl_o,
    output logic     dout_o,
    output logic     dout_oe_o,
    output logic     ceo_n_o
);
    logic rst_hit;
    logic drive;

    always_comb begin
        rst_hit     = rst_level_hit(pol_i, rst_oe_i);
        ctl_o.clear = ser_en_i & rst_hit;
        ctl_o.step  = ser_en_i & ~ce_n_i & ~rst_hit;
        drive       = ctl_o.step & ~done_i;
        dout_oe_o   = drive;
        dout_o      = drive & rd_bit_i;
        // after exhaustion, follow chip select while the enable is inactive
        ceo_n_o     = ~(ser_en_i & done_i & ~rst_hit) | ce_n_i;
    end

endmodule

// File: rtl/cfgrom_reader.sv
`timescale 1ns/1ps
module cfgrom_reader
    import cfgrom_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter bit POL_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_i,
    input  logic              ce_n_i,
    input  logic              rst_oe_i,
    input  logic              ld_we_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              ld_bit_i,
    input  logic              pol_we_i,
    input  logic              pol_bit_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              ceo_n_o
);
    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              pol_q;
    logic              rd_bit;

    cfgrom_bitstore #(
        .ADDR_W   (ADDR_W),
        .POL_INIT (POL_INIT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_i    (~ser_en_i),
        .ld_we_i   (ld_we_i),
        .ld_addr_i (ld_addr_i),
        .ld_bit_i  (ld_bit_i),
        .pol_we_i  (pol_we_i),
        .pol_bit_i (pol_bit_i),
        .rd_addr_i (addr_q),
        .rd_bit_o  (rd_bit),
        .pol_o     (pol_q)
    );

    cfgrom_addr_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl),
        .addr_o (addr_q),
        .done_o (done_q)
    );

    cfgrom_pin_ctrl u_pins (
        .ser_en_i  (ser_en_i),
        .ce_n_i    (ce_n_i),
        .rst_oe_i  (rst_oe_i),
        .pol_i     (pol_q),
        .done_i    (done_q),
        .rd_bit_i  (rd_bit),
        .ctl_o     (ctl),
        .dout_o    (dout_o),
        .dout_oe_o (dout_oe_o),
        .ceo_n_o   (ceo_n_o)
    );

endmodule

// File: rtl/cfgrom_reader_chk.sv
`timescale 1ns/1ps
module cfgrom_reader_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_en_i,
    input logic              ce_n_i,
    input logic              rst_oe_i,
    input logic              dout_o,
    input logic              dout_oe_o,
    input logic              ceo_n_o,
    input logic              pol_q,
    input logic [ADDR_W-1:0] addr_q
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    logic rst_act;
    assign rst_act = pol_q ? rst_oe_i : !rst_oe_i;

    p_dout_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |-> !dout_o);

    p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_i |-> !dout_oe_o);

    p_standby_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_i && ce_n_i && !rst_act) |=> $stable(addr_q));

    p_clear_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_i && rst_act) |=> (addr_q == '0));

    p_clear_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_i && rst_act) |-> (!dout_oe_o && ceo_n_o));

    p_handoff_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n_o |-> !dout_oe_o);

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == LAST_ADDR && ser_en_i && !rst_act) |=> (addr_q == LAST_ADDR));

    p_ceo_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n_o |-> !ce_n_i);

    p_prog_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_i |-> (!dout_oe_o && ceo_n_o));

    p_prog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_i |=> $stable(addr_q));

endmodule

bind cfgrom_reader cfgrom_reader_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_en_i  (ser_en_i),
    .ce_n_i    (ce_n_i),
    .rst_oe_i  (rst_oe_i),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o),
    .ceo_n_o   (ceo_n_o),
    .pol_q     (pol_q),
    .addr_q    (addr_q)
);

// File: tb/cfgrom_reader_bench.sv
`timescale 1ns/1ps
module cfgrom_reader_bench;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [DEPTH-1:0] PAT_A = 16'hA5C3;
    localparam logic [DEPTH-1:0] PAT_B = 16'h3C96;

    // {ser_en, ce_n, rst_oe, exp_oe, exp_d, exp_ceo_n}
    localparam int NVEC = 14;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b110_001, 6'b100_111, 6'b100_111, 6'b110_001,
        6'b100_101, 6'b100_101, 6'b101_001, 6'b100_111,
        6'b100_111, 6'b000_001, 6'b100_101, 6'b111_001,
        6'b100_111, 6'b100_111
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser = 1'b0, ce_n = 1'b1, rst_oe = 1'b0;
    logic we_a = 1'b0, we_b = 1'b0, pol_we = 1'b0, pol_bit = 1'b1;
    logic [AW-1:0] ld_addr = '0;
    logic ld_bit = 1'b0;
    logic d_a, oe_a, ceo_a, d_b, oe_b, ceo_b;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    cfgrom_reader #(.ADDR_W(AW)) u_cfgrom_reader (
        .clk(clk), .rst_n(rst_n), .ser_en_i(ser), .ce_n_i(ce_n), .rst_oe_i(rst_oe),
        .ld_we_i(we_a), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
        .pol_we_i(pol_we), .pol_bit_i(pol_bit),
        .dout_o(d_a), .dout_oe_o(oe_a), .ceo_n_o(ceo_a)
    );

    cfgrom_reader #(.ADDR_W(AW)) u_next (
        .clk(clk), .rst_n(rst_n), .ser_en_i(ser), .ce_n_i(ceo_a), .rst_oe_i(rst_oe),
        .ld_we_i(we_b), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
        .pol_we_i(1'b0), .pol_bit_i(1'b0),
        .dout_o(d_b), .dout_oe_o(oe_b), .ceo_n_o(ceo_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive after the falling edge, settle, then the caller samples
    task automatic drive(input logic s, input logic c, input logic r);
        @(negedge clk);
        ser = s; ce_n = c; rst_oe = r;
        #1;
    endtask

    task automatic load(input logic which, input int a, input logic v);
        @(negedge clk);
        ser = 1'b0; ld_addr = AW'(a); ld_bit = v;
        we_a = !which; we_b = which;
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8 reset state prog mode", {oe_a, d_a, ceo_a}, 3'b001);

        for (int i = 0; i < DEPTH; i++) begin
            load(1'b0, i, PAT_A[i]);
            load(1'b1, i, PAT_B[i]);
        end

        drive(1, 1, 0);
        chk("R2 selected-off after reset", {oe_a, d_a, ceo_a}, 3'b001);
        drive(1, 1, 1);   // clear counters

        // table walk: R1 R3 R4 R8
        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][5], VEC[v][4], VEC[v][3]);
            chk($sformatf("R1 R3 R4 R8 table step %0d", v),
                {oe_a, d_a, ceo_a}, VEC[v][2:0]);
        end

        // full read, end of array, cascade output behaviour: R1 R6 R7
        drive(1, 0, 1);
        for (int i = 0; i < DEPTH; i++) begin
            drive(1, 0, 0);
            chk($sformatf("R1 bit %0d", i), {oe_a, d_a}, {1'b1, PAT_A[i]});
        end
        drive(1, 0, 0);
        chk("R6 handoff after last bit", {oe_a, ceo_a}, 2'b00);
        drive(1, 0, 0);
        drive(1, 0, 0);
        chk("R6 no wrap", {oe_a, ceo_a}, 2'b00);
        drive(1, 1, 0);
        chk("R7 follows chip select high", {oe_a, ceo_a}, 2'b01);
        drive(1, 0, 0);
        chk("R7 follows chip select low", {oe_a, ceo_a}, 2'b00);
        drive(1, 0, 1);
        chk("R7 high while enable inactive", {oe_a, ceo_a}, 2'b01);
        drive(1, 0, 0);
        chk("R7 R4 restart from zero", {oe_a, d_a, ceo_a}, {2'b11, 1'b1});

        // polarity 0: low level of rst_oe clears (R5)
        @(negedge clk);
        ser = 1'b0; pol_bit = 1'b0; pol_we = 1'b1;
        @(negedge clk);
        pol_we = 1'b0;
        drive(1, 0, 0);
        chk("R5 low level clears with pol 0", {oe_a, ceo_a}, 2'b01);
        drive(1, 0, 1);
        chk("R5 high level enables bit0", {oe_a, d_a}, 2'b11);
        drive(1, 0, 1);
        drive(1, 0, 1);
        chk("R5 bit2", {oe_a, d_a}, {1'b1, PAT_A[2]});
        drive(1, 0, 0);
        drive(1, 0, 1);
        chk("R5 restart after low level", {oe_a, d_a}, {1'b1, PAT_A[0]});

        // writes ignored in read mode (R9)
        @(negedge clk);
        ser = 1'b1; ce_n = 1'b1; rst_oe = 1'b1;
        ld_addr = '0; ld_bit = 1'b0; we_a = 1'b1; pol_bit = 1'b1; pol_we = 1'b1;
        @(negedge clk);
        we_a = 1'b0; pol_we = 1'b0;
        drive(1, 0, 0);
        chk("R9 polarity kept in read mode", {oe_a, ceo_a}, 2'b01);
        drive(1, 0, 1);
        chk("R9 bit kept in read mode", {oe_a, d_a}, 2'b11);

        // writes accepted in programming mode (R9), polarity back to 1
        load(1'b0, 0, 1'b0);
        @(negedge clk);
        pol_bit = 1'b1; pol_we = 1'b1;
        @(negedge clk);
        pol_we = 1'b0;
        drive(1, 0, 1);
        drive(1, 0, 0);
        chk("R9 programmed bit read back", {oe_a, d_a}, 2'b10);
        load(1'b0, 0, 1'b1);

        // two chained instances (R10)
        drive(1, 0, 1);
        for (int i = 0; i < 2 * DEPTH; i++) begin
            drive(1, 0, 0);
            if (i < DEPTH) begin
                chk($sformatf("R10 chain bit %0d", i),
                    {oe_a, oe_b, d_a | d_b}, {2'b10, PAT_A[i]});
            end else begin
                chk($sformatf("R10 chain bit %0d", i),
                    {oe_a, oe_b, d_a | d_b}, {2'b01, PAT_B[i - DEPTH]});
            end
        end
        drive(1, 0, 0);
        chk("R10 chain exhausted", {oe_a, oe_b, ceo_b}, 3'b000);

        summary();
    end

endmodule